// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block sits beside a memory arbiter and watches every access that the arbiter grants. It holds four independent watchpoint channels. Each channel is programmed with a lower and an upper address bound, a mask of the operation kinds it reacts to, and a mask of the requesting clients it reacts to. When a granted access falls inside a channel's window and matches both masks, that channel raises its status bit and records the details of the access.

Software reads the status through a per-channel interrupt enable. It reads the recorded details of any channel through a channel select, and it retires a hit by acknowledging it on two separate strobes. A single combined interrupt line is high while any enabled channel is pending. A priority index names the lowest-numbered enabled pending channel, so a handler can service channel 0 first, then 1, 2 and 3.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset no channel is pending, `raw_status`, `masked_status`, `irq` and `top_valid` are all zero, and the reset configuration (lower bound all ones, upper bound zero, both masks zero) matches no access.
- R2: A channel matches only when `mon_addr` lies between its lower bound (select code 0) and its upper bound (select code 1), with both bounds included.
- R3: A channel matches only when bit `mon_client` of its client mask (select code 3, low bits of `cfg_wdata`) is set.
- R4: A channel matches only when the operation's bit of its operation mask (select code 2, `cfg_wdata[1:0]`) is set: bit 0 for a read (`mon_write` = 0), bit 1 for a write (`mon_write` = 1).
- R5: The first match on an idle channel sets its `raw_status` bit in the next cycle and records the address, the operation as a one-hot code (bit 0 read, bit 1 write), the client index as the first client, the size, and a client set holding only that client's bit.
- R6: Further matches on a pending channel add the client's bit to the recorded client set and leave the address, operation, first client and size unchanged.
- R7: `masked_status` is `raw_status` ANDed with the enable mask written via `mask_we`; a channel hits whether or not it is enabled, and shows in `masked_status` once enabled.
- R8: `irq` is high exactly when `masked_status` is non-zero.
- R9: A pending channel clears only in a cycle where both its `ch_ack` bit and its `irq_ack` bit are high; either strobe alone has no effect.
- R10: `top_ch` names the lowest-numbered channel set in `masked_status`, with `top_valid` high; channel 0 has the highest priority.
- R11: A match in the same cycle as a clearing acknowledge leaves the channel pending with a fresh record of that new access.
- R12: An access presented with `mon_valid` low is ignored by every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one configuration field |
| cfg_ch | input | 2 | Channel addressed by the configuration write |
| cfg_sel | input | 2 | Field: 0 lower bound, 1 upper bound, 2 operation mask, 3 client mask |
| cfg_wdata | input | 32 | Configuration write data |
| mask_we | input | 1 | Write the interrupt enable mask |
| mask_wdata | input | 4 | New enable mask, one bit per channel |
| ch_ack | input | 4 | Per-channel acknowledge strobes |
| irq_ack | input | 4 | Shared acknowledge strobes, one bit per channel |
| mon_valid | input | 1 | A granted access is on the monitor inputs |
| mon_addr | input | 32 | Address of the access |
| mon_client | input | 4 | Index of the requesting client |
| mon_write | input | 1 | 1 for a write, 0 for a read |
| mon_size | input | 3 | Size code of the access |
| rd_ch | input | 2 | Channel whose record is shown on the rd_ outputs |
| rd_clients | output | 14 | Recorded client set |
| rd_addr | output | 32 | Recorded address |
| rd_op | output | 2 | Recorded operation, one-hot |
| rd_first | output | 4 | Recorded first client |
| rd_size | output | 3 | Recorded size |
| raw_status | output | 4 | Pending channels before the enable mask |
| masked_status | output | 4 | Pending and enabled channels |
| irq | output | 1 | Combined interrupt |
| top_valid | output | 1 | Some enabled channel is pending |
| top_ch | output | 2 | Highest-priority enabled pending channel |

## Verification
A wrong comparator or mask decode shows one cycle after the offending access as a status bit that rises when it should stay low, or stays low when it should rise. A capture register that is not frozen shows as a changed address, operation, first client or size on the read outputs right after a second hit. A fault in the acknowledge or priority paths shows in the cycle after the strobe, as a status bit that drops early or lingers, or as a wrong `top_ch`.

// File: rtl/watch_pkg.sv
package watch_pkg;

    // Field selector for the per-channel configuration write port.
    typedef enum logic [1:0] {
        FLD_LOWER   = 2'd0,
        FLD_UPPER   = 2'd1,
        FLD_OPMASK  = 2'd2,
        FLD_CLIMASK = 2'd3
    } cfg_field_e;

    // One-hot codes recorded for the captured operation.
    localparam logic [1:0] OP_RD_CODE = 2'b01;
    localparam logic [1:0] OP_WR_CODE = 2'b10;

endpackage

// File: rtl/watch_channel.sv
module watch_channel
    import watch_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NCLI = 14,
    parameter int CW   = 4,
    parameter int SW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            mon_valid,
    input  logic [AW-1:0]   mon_addr,
    input  logic [CW-1:0]   mon_client,
    input  logic            mon_write,
    input  logic [SW-1:0]   mon_size,
    input  logic            clr,
    output logic            pend,
    output logic [NCLI-1:0] cap_cli,
    output logic [AW-1:0]   cap_addr,
    output logic [1:0]      cap_op,
    output logic [CW-1:0]   cap_first,
    output logic [SW-1:0]   cap_size
);

    typedef struct packed {
        logic [AW-1:0]   lower;
        logic [AW-1:0]   upper;
        logic [1:0]      ops;
        logic [NCLI-1:0] clis;
        logic            pend;
        logic [NCLI-1:0] cap_cli;
        logic [AW-1:0]   cap_addr;
        logic [1:0]      cap_op;
        logic [CW-1:0]   cap_first;
        logic [SW-1:0]   cap_size;
    } ch_state_t;

    ch_state_t st_q, st_d;
    logic [NCLI-1:0] cli_bit;
    logic            in_range;
    logic            hit;

    always_comb begin
        cli_bit  = NCLI'(1) << mon_client;
        in_range = (mon_addr >= st_q.lower) && (mon_addr <= st_q.upper);
        hit      = mon_valid && in_range && (|(cli_bit & st_q.clis))
                   && st_q.ops[mon_write];

        st_d = st_q;
        if (cfg_we) begin
            case (cfg_field_e'(cfg_sel))
                FLD_LOWER:   st_d.lower = cfg_wdata;
                FLD_UPPER:   st_d.upper = cfg_wdata;
                FLD_OPMASK:  st_d.ops   = cfg_wdata[1:0];
                FLD_CLIMASK: st_d.clis  = cfg_wdata[NCLI-1:0];
                default:     st_d.ops   = st_q.ops;
            endcase
        end
        if (clr) begin
            st_d.pend = 1'b0;
        end
        if (hit) begin
            if (!st_d.pend) begin
                st_d.pend      = 1'b1;
                st_d.cap_cli   = cli_bit;
                st_d.cap_addr  = mon_addr;
                st_d.cap_op    = mon_write ? OP_WR_CODE : OP_RD_CODE;
                st_d.cap_first = mon_client;
                st_d.cap_size  = mon_size;
            end else begin
                st_d.cap_cli   = st_d.cap_cli | cli_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.lower     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend      = st_q.pend;
    assign cap_cli   = st_q.cap_cli;
    assign cap_addr  = st_q.cap_addr;
    assign cap_op    = st_q.cap_op;
    assign cap_first = st_q.cap_first;
    assign cap_size  = st_q.cap_size;

    // R5
    hit_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.pend);

    // R6
    frozen_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr) |=> ($stable(st_q.cap_addr) && $stable(st_q.cap_op)
                                 && $stable(st_q.cap_first) && $stable(st_q.cap_size)));

    // R6
    client_set_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr) |=> ((st_q.cap_cli & $past(st_q.cap_cli)) == $past(st_q.cap_cli)));

    // R5
    first_in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (|(st_q.cap_cli & (NCLI'(1) << st_q.cap_first))));

    // R5
    op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> $onehot(st_q.cap_op));

endmodule

// File: rtl/watch_irq.sv
module watch_irq #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wdata,
    output logic [NCH-1:0] mstat,
    output logic           irq,
    output logic           top_valid,
    output logic [CHW-1:0] top_ch
);

    typedef struct packed {
        logic [NCH-1:0] en;
    } irq_state_t;

    irq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.en = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mstat     = raw & st_q.en;
        irq       = |mstat;
        top_valid = 1'b0;
        top_ch    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mstat[i]) begin
                top_valid = 1'b1;
                top_ch    = CHW'(i);
            end
        end
    end

    // R8
    irq_matches_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == top_valid);

    // R10
    top_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> (mstat[top_ch]
                       && ((mstat & ((NCH'(1) << top_ch) - NCH'(1))) == '0)));

    // R7
    masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mstat & ~raw) == '0);

endmodule

// File: rtl/mem_watch_unit.sv
module mem_watch_unit #(
    parameter int NCH  = 4,
    parameter int AW   = 32,
    parameter int NCLI = 14,
    parameter int SW   = 3,
    localparam int CW  = $clog2(NCLI),
    localparam int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            mask_we,
    input  logic [NCH-1:0]  mask_wdata,
    input  logic [NCH-1:0]  ch_ack,
    input  logic [NCH-1:0]  irq_ack,
    input  logic            mon_valid,
    input  logic [AW-1:0]   mon_addr,
    input  logic [CW-1:0]   mon_client,
    input  logic            mon_write,
    input  logic [SW-1:0]   mon_size,
    input  logic [CHW-1:0]  rd_ch,
    output logic [NCLI-1:0] rd_clients,
    output logic [AW-1:0]   rd_addr,
    output logic [1:0]      rd_op,
    output logic [CW-1:0]   rd_first,
    output logic [SW-1:0]   rd_size,
    output logic [NCH-1:0]  raw_status,
    output logic [NCH-1:0]  masked_status,
    output logic            irq,
    output logic            top_valid,
    output logic [CHW-1:0]  top_ch
);

    logic [NCH-1:0]  clr;
    logic [NCLI-1:0] cap_cli   [NCH];
    logic [AW-1:0]   cap_addr  [NCH];
    logic [1:0]      cap_op    [NCH];
    logic [CW-1:0]   cap_first [NCH];
    logic [SW-1:0]   cap_size  [NCH];

    assign clr = ch_ack & irq_ack;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        watch_channel #(
            .AW   (AW),
            .NCLI (NCLI),
            .CW   (CW),
            .SW   (SW)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we && (cfg_ch == CHW'(g))),
            .cfg_sel    (cfg_sel),
            .cfg_wdata  (cfg_wdata),
            .mon_valid  (mon_valid),
            .mon_addr   (mon_addr),
            .mon_client (mon_client),
            .mon_write  (mon_write),
            .mon_size   (mon_size),
            .clr        (clr[g]),
            .pend       (raw_status[g]),
            .cap_cli    (cap_cli[g]),
            .cap_addr   (cap_addr[g]),
            .cap_op     (cap_op[g]),
            .cap_first  (cap_first[g]),
            .cap_size   (cap_size[g])
        );
    end

    watch_irq #(
        .NCH (NCH),
        .CHW (CHW)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw        (raw_status),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mstat      (masked_status),
        .irq        (irq),
        .top_valid  (top_valid),
        .top_ch     (top_ch)
    );

    always_comb begin
        rd_clients = cap_cli[rd_ch];
        rd_addr    = cap_addr[rd_ch];
        rd_op      = cap_op[rd_ch];
        rd_first   = cap_first[rd_ch];
        rd_size    = cap_size[rd_ch];
    end

    // R9
    single_ack_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[0] && !(ch_ack[0] && irq_ack[0])) |=> raw_status[0]);

    // R12
    idle_bus_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_valid |=> ((raw_status & ~$past(raw_status)) == '0));

endmodule

// File: tb/tb_mem_watch_unit.sv
`timescale 1ns/100ps
module tb_mem_watch_unit;

    localparam int NCH = 4, AW = 32, NCLI = 14, SW = 3, CW = 4, CHW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CHW-1:0]  cfg_ch = '0;
    logic [1:0]      cfg_sel = '0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic            mask_we = 1'b0;
    logic [NCH-1:0]  mask_wdata = '0;
    logic [NCH-1:0]  ch_ack = '0;
    logic [NCH-1:0]  irq_ack = '0;
    logic            mon_valid = 1'b0;
    logic [AW-1:0]   mon_addr = '0;
    logic [CW-1:0]   mon_client = '0;
    logic            mon_write = 1'b0;
    logic [SW-1:0]   mon_size = '0;
    logic [CHW-1:0]  rd_ch = '0;
    logic [NCLI-1:0] rd_clients;
    logic [AW-1:0]   rd_addr;
    logic [1:0]      rd_op;
    logic [CW-1:0]   rd_first;
    logic [SW-1:0]   rd_size;
    logic [NCH-1:0]  raw_status;
    logic [NCH-1:0]  masked_status;
    logic            irq;
    logic            top_valid;
    logic [CHW-1:0]  top_ch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mem_watch_unit dut (.*);

    typedef struct {
        string           tag;
        int              ch;
        logic [NCH-1:0]  raw;
        logic [NCH-1:0]  ms;
        logic            irq_e;
        logic            tv;
        logic [CHW-1:0]  tc;
        bit              cap;
        logic [NCLI-1:0] cli;
        logic [AW-1:0]   addr;
        logic [1:0]      op;
        logic [CW-1:0]   first;
        logic [SW-1:0]   sz;
    } exp_t;

    exp_t sb[$];

    task automatic cmp(string tag, string fld, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // Monitor: pops expectations away from the active edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                rd_ch = CHW'(e.ch);
                #0.1;
                cmp(e.tag, "raw_status", AW'(raw_status), AW'(e.raw));
                cmp(e.tag, "masked_status", AW'(masked_status), AW'(e.ms));
                cmp(e.tag, "irq", AW'(irq), AW'(e.irq_e));
                cmp(e.tag, "top_valid", AW'(top_valid), AW'(e.tv));
                if (e.tv) cmp(e.tag, "top_ch", AW'(top_ch), AW'(e.tc));
                if (e.cap) begin
                    cmp(e.tag, "rd_clients", AW'(rd_clients), AW'(e.cli));
                    cmp(e.tag, "rd_addr", rd_addr, e.addr);
                    cmp(e.tag, "rd_op", AW'(rd_op), AW'(e.op));
                    cmp(e.tag, "rd_first", AW'(rd_first), AW'(e.first));
                    cmp(e.tag, "rd_size", AW'(rd_size), AW'(e.sz));
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #0.5;
        cfg_we = 1'b0; mask_we = 1'b0; mon_valid = 1'b0;
        ch_ack = '0; irq_ack = '0;
    endtask

    task automatic push_st(string tag, logic [NCH-1:0] raw, logic [NCH-1:0] ms,
                           logic tv, logic [CHW-1:0] tc);
        exp_t e;
        e.tag = tag; e.ch = 0; e.raw = raw; e.ms = ms; e.irq_e = tv;
        e.tv = tv; e.tc = tc; e.cap = 1'b0;
        e.cli = '0; e.addr = '0; e.op = '0; e.first = '0; e.sz = '0;
        sb.push_back(e);
    endtask

    task automatic push_cap(string tag, int ch, logic [NCH-1:0] raw, logic [NCH-1:0] ms,
                            logic tv, logic [CHW-1:0] tc, logic [NCLI-1:0] cli,
                            logic [AW-1:0] a, logic [1:0] op, logic [CW-1:0] first,
                            logic [SW-1:0] sz);
        exp_t e;
        e.tag = tag; e.ch = ch; e.raw = raw; e.ms = ms; e.irq_e = tv;
        e.tv = tv; e.tc = tc; e.cap = 1'b1;
        e.cli = cli; e.addr = a; e.op = op; e.first = first; e.sz = sz;
        sb.push_back(e);
    endtask

    task automatic cfg(int ch, int sel, logic [AW-1:0] v);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
        cyc();
    endtask

    task automatic setmask(logic [NCH-1:0] m);
        mask_we = 1'b1; mask_wdata = m;
        cyc();
    endtask

    task automatic drive_acc(logic [AW-1:0] a, int cli, bit wr, int sz, bit vld);
        mon_valid = vld; mon_addr = a; mon_client = CW'(cli);
        mon_write = wr; mon_size = SW'(sz);
    endtask

    task automatic acc(logic [AW-1:0] a, int cli, bit wr, int sz);
        drive_acc(a, cli, wr, sz, 1'b1);
        cyc();
    endtask

    initial begin
        #40000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        cyc();
        push_st("R1 reset state", 4'b0000, 4'b0000, 1'b0, 2'd0);
        acc(32'h0, 0, 1'b0, 0);
        acc(32'hFFFF_FFFF, 13, 1'b1, 0);
        push_st("R1 reset config matches nothing", 4'b0000, 4'b0000, 1'b0, 2'd0);

        // Channel 0: window 0x100..0x1FF, reads only, clients 2 and 5.
        cfg(0, 0, 32'h100);
        cfg(0, 1, 32'h1FF);
        cfg(0, 2, 32'h1);
        cfg(0, 3, 32'h24);
        setmask(4'b1111);

        acc(32'h0FF, 2, 1'b0, 1);
        push_st("R2 below lower bound", 4'b0000, 4'b0000, 1'b0, 2'd0);
        acc(32'h200, 2, 1'b0, 1);
        push_st("R2 above upper bound", 4'b0000, 4'b0000, 1'b0, 2'd0);
        acc(32'h150, 2, 1'b1, 1);
        push_st("R4 write with read-only mask", 4'b0000, 4'b0000, 1'b0, 2'd0);
        acc(32'h150, 3, 1'b0, 1);
        push_st("R3 client not in mask", 4'b0000, 4'b0000, 1'b0, 2'd0);
        drive_acc(32'h150, 2, 1'b0, 1, 1'b0);
        cyc();
        push_st("R12 mon_valid low ignored", 4'b0000, 4'b0000, 1'b0, 2'd0);

        acc(32'h100, 2, 1'b0, 3);
        push_cap("R5 R2 first hit at lower bound", 0, 4'b0001, 4'b0001, 1'b1, 2'd0,
                 14'h0004, 32'h100, 2'b01, 4'd2, 3'd3);
        acc(32'h1FF, 5, 1'b0, 1);
        push_cap("R6 R2 second hit at upper bound", 0, 4'b0001, 4'b0001, 1'b1, 2'd0,
                 14'h0024, 32'h100, 2'b01, 4'd2, 3'd3);

        ch_ack = 4'b0001;
        cyc();
        push_st("R9 channel ack alone", 4'b0001, 4'b0001, 1'b1, 2'd0);
        irq_ack = 4'b0001;
        cyc();
        push_st("R9 shared ack alone", 4'b0001, 4'b0001, 1'b1, 2'd0);
        ch_ack = 4'b0001; irq_ack = 4'b0001;
        cyc();
        push_st("R9 both acks clear", 4'b0000, 4'b0000, 1'b0, 2'd0);

        // Channel 1: single address 0x1000, writes only, client 7.
        cfg(1, 0, 32'h1000);
        cfg(1, 1, 32'h1000);
        cfg(1, 2, 32'h2);
        cfg(1, 3, 32'h80);
        // Channel 3: whole low space, both operations, all clients.
        cfg(3, 0, 32'h0);
        cfg(3, 1, 32'hFFFF);
        cfg(3, 2, 32'h3);
        cfg(3, 3, 32'h3FFF);
        setmask(4'b0001);

        acc(32'h1000, 7, 1'b1, 2);
        push_st("R7 R8 hits while disabled", 4'b1010, 4'b0000, 1'b0, 2'd0);
        setmask(4'b1111);
        push_cap("R7 R10 enable shows pending", 3, 4'b1010, 4'b1010, 1'b1, 2'd1,
                 14'h0080, 32'h1000, 2'b10, 4'd7, 3'd2);
        push_cap("R5 channel 1 record", 1, 4'b1010, 4'b1010, 1'b1, 2'd1,
                 14'h0080, 32'h1000, 2'b10, 4'd7, 3'd2);
        setmask(4'b1000);
        push_st("R10 R8 mask picks channel 3", 4'b1010, 4'b1000, 1'b1, 2'd3);
        setmask(4'b1111);
        ch_ack = 4'b0010; irq_ack = 4'b0010;
        cyc();
        push_st("R10 after clearing channel 1", 4'b1000, 4'b1000, 1'b1, 2'd3);

        drive_acc(32'h20, 0, 1'b0, 0, 1'b1);
        ch_ack = 4'b1000; irq_ack = 4'b1000;
        cyc();
        push_cap("R11 hit during ack re-arms", 3, 4'b1000, 4'b1000, 1'b1, 2'd3,
                 14'h0001, 32'h20, 2'b01, 4'd0, 3'd0);
        ch_ack = 4'b1000; irq_ack = 4'b1000;
        cyc();
        push_st("R9 R8 final clear", 4'b0000, 4'b0000, 1'b0, 2'd0);

        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule